// File: doc/BRIEF.md
# Boot Strap Latch and Code-Region Remapper

This block decides, at start-up, which memory answers at address zero. Two strap inputs are captured a fixed number of clock edges after reset is released, and captured again after every standby exit. The captured pattern selects one of three memories to appear at address zero: main flash, the system ROM or on-chip SRAM. A software mode register starts from the captured pattern. It can later switch the alias to another memory, including an external memory bank. When capture completes, the block raises a done flag so that the CPU start-up logic can fetch the stack pointer from address 0x0000_0000 and the start vector from 0x0000_0004.

Every address presented on the request port is translated, one cycle later, into a target memory select and a byte offset. Addresses inside the 128 MB zero window map to the currently aliased memory. The aliased memories also stay reachable through their own native windows. An address in the zero window beyond the end of the aliased memory is marked reserved, and so is any address outside every window.

Top module: `boot_remap_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `boot_done_o` and `rsp_valid_o` are 0. In that state `pin_mode_o` and `map_mode_o` are both 00.
- R2: The straps are captured on the 4th rising clock edge after reset is released. `boot_done_o` rises on that same edge. Strap changes made after that edge do not change `pin_mode_o`.
- R3: The straps are decoded as follows. `strap_lo_i`=0 gives mode 00 (flash), whatever `strap_hi_i` is. `strap_lo_i`=1 with `strap_hi_i`=0 gives mode 01 (system ROM). Both straps at 1 give mode 11 (SRAM).
- R4: A one-cycle `wake_i` pulse clears `boot_done_o` on the edge where the pulse is sampled. The straps are then captured again on the 4th following edge, and that capture also reloads `map_mode_o` with the new strap mode.
- R5: A write on `cfg_wr_i` loads `cfg_wdata_i` into `map_mode_o` on the next edge, but only while `boot_done_o` is 1 and `wake_i` is 0; a write at any other time is ignored. The mode codes are 00 flash, 01 system ROM, 11 SRAM and 10 external bank.
- R6: An address below 0x0800_0000 that lies inside the aliased memory's size returns `rsp_sel_o` for that memory, with `rsp_offset_o` equal to the address. The select codes are 0 flash, 1 system ROM, 2 SRAM, 3 external bank and 4 none.
- R7: The alias sizes are 1 MB for flash, 30 KB for the system ROM, 112 KB for SRAM and 128 MB for the external bank. A zero-window address at or beyond the aliased size returns `rsp_reserved_o`=1, `rsp_sel_o`=4 and `rsp_offset_o`=0.
- R8: Each memory stays reachable at its native window in every mode. Flash sits at 0x0800_0000 (1 MB), the system ROM at 0x1FFF_0000 (30 KB) and SRAM at 0x2000_0000 (112 KB). The offset returned is the address minus the window base.
- R9: Any other address returns `rsp_reserved_o`=1, `rsp_sel_o`=4 and `rsp_offset_o`=0.
- R10: `rsp_valid_o` follows `req_valid_i` by exactly one cycle. Each response uses the `map_mode_o` value of the cycle in which its request was sampled, and back-to-back requests are answered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wake_i | input | 1 | One-cycle pulse on standby exit |
| strap_lo_i | input | 1 | Low boot strap |
| strap_hi_i | input | 1 | High boot strap |
| cfg_wr_i | input | 1 | Mode register write strobe |
| cfg_wdata_i | input | 2 | Mode register write value |
| req_valid_i | input | 1 | Translation request valid |
| req_addr_i | input | 32 | Address to translate |
| boot_done_o | output | 1 | Strap capture complete |
| pin_mode_o | output | 2 | Mode decoded from the captured straps |
| map_mode_o | output | 2 | Mode currently aliased at zero |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_sel_o | output | 3 | Target memory select |
| rsp_offset_o | output | 32 | Byte offset within the target memory |
| rsp_reserved_o | output | 1 | Address hits no mapped memory |

## Verification
The translator is exercised in all four alias modes. In each mode the bench probes address 0, the vector word at 4, the last byte inside the alias and the first byte past it. Together these show whether the alias size tracks the mode and whether the reserved flag falls at the right boundary. The same native-window addresses are sent in every mode to tell a true native hit apart from a leaked alias. The straps are also changed around the capture edge, both after reset and after a wake pulse, which pins down the exact edge and shows that a late strap change is ignored.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

    // Alias mode codes held in the mode register
    typedef enum logic [1:0] {
        MAP_FLASH  = 2'b00,
        MAP_SYSROM = 2'b01,
        MAP_EXTBUS = 2'b10,
        MAP_SRAM   = 2'b11
    } map_mode_e;

    // Target memory select codes
    typedef enum logic [2:0] {
        SEL_FLASH  = 3'd0,
        SEL_SYSROM = 3'd1,
        SEL_SRAM   = 3'd2,
        SEL_EXTBUS = 3'd3,
        SEL_NONE   = 3'd4
    } mem_sel_e;

    typedef struct packed {
        logic        reserved;
        mem_sel_e    sel;
        logic [31:0] offset;
    } xlate_rsp_t;

    localparam logic [31:0] ZERO_WIN_BYTES_D = 32'h0800_0000;
    localparam logic [31:0] FLASH_BASE_D     = 32'h0800_0000;
    localparam logic [31:0] FLASH_BYTES_D    = 32'h0010_0000;
    localparam logic [31:0] SYSROM_BASE_D    = 32'h1FFF_0000;
    localparam logic [31:0] SYSROM_BYTES_D   = 32'h0000_7800;
    localparam logic [31:0] SRAM_BASE_D      = 32'h2000_0000;
    localparam logic [31:0] SRAM_BYTES_D     = 32'h0001_C000;
    localparam logic [31:0] EXT_BYTES_D      = 32'h0800_0000;

    // Low strap clear selects flash regardless of the high strap
    function automatic map_mode_e decode_straps(input logic hi, input logic lo);
        if (!lo)
            return MAP_FLASH;
        else if (!hi)
            return MAP_SYSROM;
        else
            return MAP_SRAM;
    endfunction

    function automatic logic in_window(input logic [31:0] addr,
                                       input logic [31:0] base,
                                       input logic [31:0] size);
        return (addr >= base) && ((addr - base) < size);
    endfunction

endpackage

// File: rtl/boot_strap_sampler.sv
module boot_strap_sampler
    import boot_map_pkg::*;
#(
    parameter int SAMPLE_EDGE = 4
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      wake_i,
    input  logic      strap_lo_i,
    input  logic      strap_hi_i,
    output map_mode_e pin_mode_o,
    output logic      done_o,
    output logic      load_o
);
    localparam int CW = $clog2(SAMPLE_EDGE + 1);
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_EDGE - 1);

    logic [CW-1:0] cnt_q;

    // Capture fires on the edge where the counter has seen SAMPLE_EDGE-1 edges
    assign load_o = !done_o && !wake_i && (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q      <= '0;
            done_o     <= 1'b0;
            pin_mode_o <= MAP_FLASH;
        end else if (wake_i) begin
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else if (load_o) begin
            pin_mode_o <= decode_straps(strap_hi_i, strap_lo_i);
            done_o     <= 1'b1;
        end else if (!done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    done_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !wake_i) |=> done_o);

    // R2
    pin_mode_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !wake_i) |=> $stable(pin_mode_o));

    // R4
    wake_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_i |=> !done_o);

endmodule

// File: rtl/boot_mode_reg.sv
module boot_mode_reg
    import boot_map_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       load_i,
    input  map_mode_e  load_mode_i,
    input  logic       done_i,
    input  logic       wake_i,
    input  logic       wr_i,
    input  logic [1:0] wdata_i,
    output map_mode_e  mode_o
);
    logic wr_ok;

    assign wr_ok = wr_i && done_i && !wake_i;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            mode_o <= MAP_FLASH;
        else if (load_i)
            mode_o <= load_mode_i;
        else if (wr_ok)
            mode_o <= map_mode_e'(wdata_i);
    end

    // R5
    early_write_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!done_i && !load_i) |=> $stable(mode_o));

    // R5
    write_lands_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && done_i && !wake_i) |=> (mode_o == map_mode_e'($past(wdata_i))));

endmodule

// File: rtl/boot_addr_xlate.sv
module boot_addr_xlate
    import boot_map_pkg::*;
#(
    parameter logic [31:0] ZERO_WIN_BYTES = ZERO_WIN_BYTES_D,
    parameter logic [31:0] FLASH_BASE     = FLASH_BASE_D,
    parameter logic [31:0] FLASH_BYTES    = FLASH_BYTES_D,
    parameter logic [31:0] SYSROM_BASE    = SYSROM_BASE_D,
    parameter logic [31:0] SYSROM_BYTES   = SYSROM_BYTES_D,
    parameter logic [31:0] SRAM_BASE      = SRAM_BASE_D,
    parameter logic [31:0] SRAM_BYTES     = SRAM_BYTES_D,
    parameter logic [31:0] EXT_BYTES      = EXT_BYTES_D
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  map_mode_e   mode_i,
    input  logic        req_valid_i,
    input  logic [31:0] req_addr_i,
    output logic        rsp_valid_o,
    output xlate_rsp_t  rsp_o
);
    localparam int NWIN = 3;

    logic [NWIN-1:0] nat_hit;
    logic [31:0]     nat_off [NWIN];
    mem_sel_e        nat_sel [NWIN];

    // Native windows stay decoded in every mode
    for (genvar g = 0; g < NWIN; g++) begin : g_native
        localparam logic [31:0] WB = (g == 0) ? FLASH_BASE  : (g == 1) ? SYSROM_BASE  : SRAM_BASE;
        localparam logic [31:0] WS = (g == 0) ? FLASH_BYTES : (g == 1) ? SYSROM_BYTES : SRAM_BYTES;
        localparam mem_sel_e    WM = (g == 0) ? SEL_FLASH   : (g == 1) ? SEL_SYSROM   : SEL_SRAM;
        assign nat_hit[g] = in_window(req_addr_i, WB, WS);
        assign nat_off[g] = req_addr_i - WB;
        assign nat_sel[g] = WM;
    end

    logic [31:0] alias_lim;
    mem_sel_e    alias_sel;
    xlate_rsp_t  nxt;

    always_comb begin
        unique case (mode_i)
            MAP_FLASH:  begin alias_lim = FLASH_BYTES;  alias_sel = SEL_FLASH;  end
            MAP_SYSROM: begin alias_lim = SYSROM_BYTES; alias_sel = SEL_SYSROM; end
            MAP_SRAM:   begin alias_lim = SRAM_BYTES;   alias_sel = SEL_SRAM;   end
            MAP_EXTBUS: begin alias_lim = EXT_BYTES;    alias_sel = SEL_EXTBUS; end
            default:    begin alias_lim = '0;           alias_sel = SEL_NONE;   end
        endcase
    end

    always_comb begin
        nxt.reserved = 1'b1;
        nxt.sel      = SEL_NONE;
        nxt.offset   = '0;
        if (req_addr_i < ZERO_WIN_BYTES) begin
            if (req_addr_i < alias_lim) begin
                nxt.reserved = 1'b0;
                nxt.sel      = alias_sel;
                nxt.offset   = req_addr_i;
            end
        end else begin
            for (int w = 0; w < NWIN; w++) begin
                if (nat_hit[w]) begin
                    nxt.reserved = 1'b0;
                    nxt.sel      = nat_sel[w];
                    nxt.offset   = nat_off[w];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rsp_valid_o <= 1'b0;
            rsp_o       <= '{reserved: 1'b0, sel: SEL_NONE, offset: '0};
        end else begin
            rsp_valid_o <= req_valid_i;
            if (req_valid_i)
                rsp_o <= nxt;
        end
    end

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        req_valid_i |=> rsp_valid_o);

    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_i |=> !rsp_valid_o);

    // R7
    reserved_shape_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rsp_valid_o && rsp_o.reserved) |-> (rsp_o.sel == SEL_NONE && rsp_o.offset == '0));

    // R6
    offset_bounded_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rsp_valid_o && !rsp_o.reserved) |-> (rsp_o.offset < ZERO_WIN_BYTES && rsp_o.sel != SEL_NONE));

endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
    import boot_map_pkg::*;
#(
    parameter int          SAMPLE_EDGE    = 4,
    parameter logic [31:0] ZERO_WIN_BYTES = ZERO_WIN_BYTES_D,
    parameter logic [31:0] FLASH_BASE     = FLASH_BASE_D,
    parameter logic [31:0] FLASH_BYTES    = FLASH_BYTES_D,
    parameter logic [31:0] SYSROM_BASE    = SYSROM_BASE_D,
    parameter logic [31:0] SYSROM_BYTES   = SYSROM_BYTES_D,
    parameter logic [31:0] SRAM_BASE      = SRAM_BASE_D,
    parameter logic [31:0] SRAM_BYTES     = SRAM_BYTES_D,
    parameter logic [31:0] EXT_BYTES      = EXT_BYTES_D
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        wake_i,
    input  logic        strap_lo_i,
    input  logic        strap_hi_i,
    input  logic        cfg_wr_i,
    input  logic [1:0]  cfg_wdata_i,
    input  logic        req_valid_i,
    input  logic [31:0] req_addr_i,
    output logic        boot_done_o,
    output logic [1:0]  pin_mode_o,
    output logic [1:0]  map_mode_o,
    output logic        rsp_valid_o,
    output logic [2:0]  rsp_sel_o,
    output logic [31:0] rsp_offset_o,
    output logic        rsp_reserved_o
);
    map_mode_e  pin_mode;
    map_mode_e  map_mode;
    logic       done;
    logic       load;
    xlate_rsp_t rsp;

    boot_strap_sampler #(.SAMPLE_EDGE(SAMPLE_EDGE)) i_sampler (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wake_i     (wake_i),
        .strap_lo_i (strap_lo_i),
        .strap_hi_i (strap_hi_i),
        .pin_mode_o (pin_mode),
        .done_o     (done),
        .load_o     (load)
    );

    boot_mode_reg i_mode_reg (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .load_i      (load),
        .load_mode_i (decode_straps(strap_hi_i, strap_lo_i)),
        .done_i      (done),
        .wake_i      (wake_i),
        .wr_i        (cfg_wr_i),
        .wdata_i     (cfg_wdata_i),
        .mode_o      (map_mode)
    );

    boot_addr_xlate #(
        .ZERO_WIN_BYTES (ZERO_WIN_BYTES),
        .FLASH_BASE     (FLASH_BASE),
        .FLASH_BYTES    (FLASH_BYTES),
        .SYSROM_BASE    (SYSROM_BASE),
        .SYSROM_BYTES   (SYSROM_BYTES),
        .SRAM_BASE      (SRAM_BASE),
        .SRAM_BYTES     (SRAM_BYTES),
        .EXT_BYTES      (EXT_BYTES)
    ) i_xlate (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .mode_i      (map_mode),
        .req_valid_i (req_valid_i),
        .req_addr_i  (req_addr_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_o       (rsp)
    );

    assign boot_done_o    = done;
    assign pin_mode_o     = pin_mode;
    assign map_mode_o     = map_mode;
    assign rsp_sel_o      = rsp.sel;
    assign rsp_offset_o   = rsp.offset;
    assign rsp_reserved_o = rsp.reserved;

    // R4
    capture_reloads_map_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(done) |-> (map_mode == pin_mode));

endmodule

// File: tb/test_boot_remap_ctrl.sv
module test_boot_remap_ctrl;

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        wake_i = 1'b0;
    logic        strap_lo_i = 1'b0;
    logic        strap_hi_i = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [1:0]  cfg_wdata_i = 2'b00;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic        boot_done_o;
    logic [1:0]  pin_mode_o;
    logic [1:0]  map_mode_o;
    logic        rsp_valid_o;
    logic [2:0]  rsp_sel_o;
    logic [31:0] rsp_offset_o;
    logic        rsp_reserved_o;

    boot_remap_ctrl i_boot_remap_ctrl (
        .clk_i          (clk),
        .rst_i          (rst_i),
        .wake_i         (wake_i),
        .strap_lo_i     (strap_lo_i),
        .strap_hi_i     (strap_hi_i),
        .cfg_wr_i       (cfg_wr_i),
        .cfg_wdata_i    (cfg_wdata_i),
        .req_valid_i    (req_valid_i),
        .req_addr_i     (req_addr_i),
        .boot_done_o    (boot_done_o),
        .pin_mode_o     (pin_mode_o),
        .map_mode_o     (map_mode_o),
        .rsp_valid_o    (rsp_valid_o),
        .rsp_sel_o      (rsp_sel_o),
        .rsp_offset_o   (rsp_offset_o),
        .rsp_reserved_o (rsp_reserved_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [35:0] v;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [1:0]  exp_mode = 2'b00;

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Straps {hi,lo}: x0 flash 00, 01 system ROM 01, 11 SRAM 11
    function automatic logic [1:0] strap_mode(input logic hi, input logic lo);
        case ({hi, lo})
            2'b01:   return 2'b01;
            2'b11:   return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic exp_t model(input logic [31:0] a, input logic [1:0] m);
        logic [31:0] lim;
        logic [2:0]  s;
        case (m)
            2'b00:   begin lim = 32'h0010_0000; s = 3'd0; end
            2'b01:   begin lim = 32'h0000_7800; s = 3'd1; end
            2'b11:   begin lim = 32'h0001_C000; s = 3'd2; end
            default: begin lim = 32'h0800_0000; s = 3'd3; end
        endcase
        if (a < 32'h0800_0000) begin
            if (a < lim) return '{v: {1'b0, s, a}, tag: "R6"};
            return '{v: {1'b1, 3'd4, 32'd0}, tag: "R7"};
        end
        if (a >= 32'h0800_0000 && a < 32'h0810_0000)
            return '{v: {1'b0, 3'd0, a - 32'h0800_0000}, tag: "R8"};
        if (a >= 32'h1FFF_0000 && a < 32'h1FFF_7800)
            return '{v: {1'b0, 3'd1, a - 32'h1FFF_0000}, tag: "R8"};
        if (a >= 32'h2000_0000 && a < 32'h2001_C000)
            return '{v: {1'b0, 3'd2, a - 32'h2000_0000}, tag: "R8"};
        return '{v: {1'b1, 3'd4, 32'd0}, tag: "R9"};
    endfunction

    // Driver: one request per call, back-to-back when called in a row
    task automatic req(input logic [31:0] a);
        req_valid_i = 1'b1;
        req_addr_i  = a;
        sb_q.push_back(model(a, exp_mode));
        step(1);
        req_valid_i = 1'b0;
    endtask

    task automatic write_mode(input logic [1:0] m);
        cfg_wr_i    = 1'b1;
        cfg_wdata_i = m;
        if (boot_done_o && !wake_i) exp_mode = m;
        step(1);
        cfg_wr_i = 1'b0;
    endtask

    task automatic do_reset(input logic hi, input logic lo);
        strap_hi_i = hi;
        strap_lo_i = lo;
        rst_i = 1'b1;
        step(2);
        rst_i = 1'b0;
        step(4);
        exp_mode = strap_mode(hi, lo);
        check("R3 strap decode", {34'd0, pin_mode_o}, {34'd0, exp_mode});
        check("R3 map follows straps", {34'd0, map_mode_o}, {34'd0, exp_mode});
    endtask

    task automatic sweep_common();
        req(32'h0000_0000);
        req(32'h0000_0004);
        req(32'h0000_77FF);
        req(32'h0000_7800);
        req(32'h0001_BFFF);
        req(32'h0001_C000);
        req(32'h000F_FFFF);
        req(32'h0010_0000);
        req(32'h07FF_FFFF);
        req(32'h0800_0000);
        req(32'h080F_FFFC);
        req(32'h0810_0000);
        req(32'h1FFF_0000);
        req(32'h1FFF_77FF);
        req(32'h1FFF_7800);
        req(32'h2000_0000);
        req(32'h2001_BFFF);
        req(32'h2001_C000);
        req(32'h4000_0000);
        step(2);
    endtask

    // Monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (!rst_i && rsp_valid_o) begin
            if (sb_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10 actual unexpected response expected none");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, {rsp_reserved_o, rsp_sel_o, rsp_offset_o}, e.v);
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        // R1 reset state
        check("R1 reset outputs", {32'd0, boot_done_o, rsp_valid_o, map_mode_o},
              36'd0);
        check("R1 pin mode", {34'd0, pin_mode_o}, 36'd0);

        // R2 capture edge: straps change just before the 4th edge
        strap_hi_i = 1'b0;
        strap_lo_i = 1'b1;
        rst_i = 1'b0;
        step(1);
        check("R1 first cycle done", {35'd0, boot_done_o}, 36'd0);
        step(2);
        check("R2 not done before edge 4", {35'd0, boot_done_o}, 36'd0);
        strap_hi_i = 1'b1;
        step(1);
        check("R2 done on edge 4", {35'd0, boot_done_o}, 36'd1);
        check("R2 captured on edge 4", {34'd0, pin_mode_o}, {34'd0, 2'b11});
        check("R2 map loaded", {34'd0, map_mode_o}, {34'd0, 2'b11});
        exp_mode = 2'b11;
        strap_hi_i = 1'b0;
        strap_lo_i = 1'b0;
        step(3);
        check("R2 late strap change ignored", {34'd0, pin_mode_o}, {34'd0, 2'b11});

        sweep_common();

        // R3 remaining strap patterns
        do_reset(1'b0, 1'b0);
        do_reset(1'b1, 1'b0);
        sweep_common();
        do_reset(1'b0, 1'b1);
        sweep_common();

        // R5 software switch to the external bank
        write_mode(2'b10);
        check("R5 write lands", {34'd0, map_mode_o}, {34'd0, 2'b10});
        sweep_common();

        // R4 wake resample, with an early write that must be ignored (R5)
        strap_hi_i = 1'b1;
        strap_lo_i = 1'b1;
        wake_i = 1'b1;
        step(1);
        wake_i = 1'b0;
        check("R4 wake clears done", {35'd0, boot_done_o}, 36'd0);
        write_mode(2'b00);
        check("R5 write before done ignored", {34'd0, map_mode_o}, {34'd0, 2'b10});
        step(2);
        check("R4 not done before 4th edge", {35'd0, boot_done_o}, 36'd0);
        step(1);
        check("R4 done after resample", {35'd0, boot_done_o}, 36'd1);
        check("R4 resampled straps", {34'd0, pin_mode_o}, {34'd0, 2'b11});
        check("R4 map reloaded", {34'd0, map_mode_o}, {34'd0, 2'b11});
        exp_mode = 2'b11;

        // R10 mode change between back-to-back requests
        req(32'h0001_0000);
        write_mode(2'b00);
        req(32'h0001_0000);
        req(32'h0010_0000);
        step(2);
        sweep_common();

        check("R10 scoreboard drained", {4'd0, 32'(sb_q.size())}, 36'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule